// File: doc/BRIEF.md
# Capture/Reload Timer with Event Flags

A timer/counter whose count register is built from equal-width bytes. Each byte can be written by software. The count advances by one step on every cycle in which both the run control and the tick input are high. It counts up or down. In reload mode, an up-count that passes the all-ones value loads the count from a capture/reload register. In capture mode, the same up-count wraps to zero. A down-count that reaches the value in the capture/reload register loads all-ones. Either kind of terminal event sets a sticky overflow flag. The flag is not set while either baud-clock mode bit is high.

An external trigger pin is brought into the clock domain through a synchronizer, and its falling edges are detected. While the external enable is high, a falling edge does one of two things. In capture mode it copies the live count into the capture/reload register. In reload mode it loads the count from that register. In both modes it sets a sticky external flag. Software can set or clear either flag by writing it. Writing 1 to the external flag is how software forces an interrupt. The interrupt request is the OR of the two flags, gated by an enable input.

Top module: `capture_reload_timer`

## Requirements
- R1: With `run`=1, `tick`=1, `dir_down`=0, no count byte write and no trigger reload, the count rises by 1 on the next clock edge, unless the count is all-ones.
- R2: An up-count step from all-ones loads the capture/reload register when `cap_mode`=0. It loads zero when `cap_mode`=1.
- R3: With `dir_down`=1, a step decrements the count. When the count already equals the capture/reload register, the step loads all-ones instead.
- R4: The terminal events of R2 and R3 set `ovf_flag` on the same edge, but only when `rx_baud` and `tx_baud` are both 0.
- R5: A falling edge on `trig_in` is acted on at the third clock edge after the pin falls (two synchronizer flops, then an edge register). This happens only while `ext_en`=1. In capture mode, the count is copied into `capture`. In reload mode, `capture` is loaded into the count. In both modes `ext_flag` is set.
- R6: While `ext_en`=0, a falling edge on `trig_in` changes neither `capture`, the count nor `ext_flag`.
- R7: Both flags hold their value until written. A write strobe (`ovf_wr` or `ext_wr`) loads `flag_wdata` into its flag. A hardware set in the same cycle wins over a software write of 0.
- R8: `irq` is high exactly when `irq_en`=1 and at least one flag is set. A software write of 1 to `ext_flag` therefore raises `irq`.
- R9: Bit i of `cnt_byte_we` loads `wr_data` into byte i of the count (byte 0 holds the least significant bits). Such a write takes priority over reloads and steps, and it blocks stepping in that cycle. Bits of `cap_byte_we` load bytes of `capture` in the same way. A hardware capture in the same cycle wins over a byte write to `capture`.
- R10: After reset, the count, `capture` and both flags are 0, and `irq` is 0.
- R11: While `run` or `tick` is 0, and no write or trigger reload occurs, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting enable |
| tick | input | 1 | Count pulse, qualified by run |
| dir_down | input | 1 | 1 = count down |
| cap_mode | input | 1 | 1 = capture mode, 0 = reload mode |
| ext_en | input | 1 | Enables trigger edges |
| trig_in | input | 1 | Asynchronous trigger pin |
| rx_baud | input | 1 | Receive baud-clock mode bit |
| tx_baud | input | 1 | Transmit baud-clock mode bit |
| irq_en | input | 1 | Interrupt enable |
| cnt_byte_we | input | NUM_BYTES | Per-byte write strobes for the count |
| cap_byte_we | input | NUM_BYTES | Per-byte write strobes for the capture/reload register |
| wr_data | input | BYTE_W | Byte write data |
| ovf_wr | input | 1 | Software write strobe for the overflow flag |
| ext_wr | input | 1 | Software write strobe for the external flag |
| flag_wdata | input | 1 | Value written to a flag |
| count | output | BYTE_W*NUM_BYTES | Current count |
| capture | output | BYTE_W*NUM_BYTES | Capture/reload register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: two 8-bit bytes and a two-stage synchronizer, which gives a 16-bit count. Byte writes can preload the count near all-ones or near a match value, so wrap, reload and down-count terminal events are reached within a few cycles instead of 65536. The three-edge trigger latency is fixed by the stage count, so the bench can place a trigger edge in the same cycle as other events and check that the capture, reload and flag effects land where they should.

// File: rtl/crt_pkg.sv
package crt_pkg;

   typedef enum logic {
      MODE_RELOAD  = 1'b0,
      MODE_CAPTURE = 1'b1
   } crt_mode_e;

   typedef struct packed {
      logic set;
      logic we;
      logic wd;
   } flag_ctl_t;

endpackage

// File: rtl/crt_trig_sync.sv
module crt_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= pin;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];
   end

   assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BYTES-1:0]          byte_we,
   input  logic [BYTE_W-1:0]             wdata,
   input  logic                          reload_now,
   input  logic [BYTE_W*NUM_BYTES-1:0]   reload_val,
   input  logic                          step_en,
   input  logic                          dir_down,
   input  crt_pkg::crt_mode_e            mode,
   output logic [BYTE_W*NUM_BYTES-1:0]   cnt,
   output logic                          term_evt
);
   localparam int CW = BYTE_W * NUM_BYTES;
   localparam logic [CW-1:0] ALL_ONES = '1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] step_val;
   logic          at_end;
   logic          any_we;

   assign any_we = |byte_we;

   always_comb begin
      if (!dir_down) begin
         at_end = (cnt_q == ALL_ONES);
         if (at_end)
            step_val = (mode == crt_pkg::MODE_CAPTURE) ? '0 : reload_val;
         else
            step_val = cnt_q + 1'b1;
      end else begin
         at_end   = (cnt_q == reload_val);
         step_val = at_end ? ALL_ONES : cnt_q - 1'b1;
      end
   end

   assign term_evt = step_en & ~any_we & ~reload_now & at_end;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[b*BYTE_W +: BYTE_W] <= '0;
         else if (byte_we[b])
            cnt_q[b*BYTE_W +: BYTE_W] <= wdata;
         else if (!any_we) begin
            if (reload_now)
               cnt_q[b*BYTE_W +: BYTE_W] <= reload_val[b*BYTE_W +: BYTE_W];
            else if (step_en)
               cnt_q[b*BYTE_W +: BYTE_W] <= step_val[b*BYTE_W +: BYTE_W];
         end
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/crt_capreg.sv
module crt_capreg #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BYTES-1:0]        byte_we,
   input  logic [BYTE_W-1:0]           wdata,
   input  logic                        grab,
   input  logic [BYTE_W*NUM_BYTES-1:0] grab_val,
   output logic [BYTE_W*NUM_BYTES-1:0] cap
);
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cap[b*BYTE_W +: BYTE_W] <= '0;
         else if (grab)
            cap[b*BYTE_W +: BYTE_W] <= grab_val[b*BYTE_W +: BYTE_W];
         else if (byte_we[b])
            cap[b*BYTE_W +: BYTE_W] <= wdata;
      end
   end
endmodule

// File: rtl/crt_flag.sv
module crt_flag (
   input  logic               clk,
   input  logic               rst_n,
   input  crt_pkg::flag_ctl_t ctl,
   output logic               q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (ctl.set) q <= 1'b1;
      else if (ctl.we)  q <= ctl.wd;
   end
endmodule

// File: rtl/capture_reload_timer.sv
module capture_reload_timer #(
   parameter int BYTE_W      = 8,
   parameter int NUM_BYTES   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic                        tick,
   input  logic                        dir_down,
   input  logic                        cap_mode,
   input  logic                        ext_en,
   input  logic                        trig_in,
   input  logic                        rx_baud,
   input  logic                        tx_baud,
   input  logic                        irq_en,
   input  logic [NUM_BYTES-1:0]        cnt_byte_we,
   input  logic [NUM_BYTES-1:0]        cap_byte_we,
   input  logic [BYTE_W-1:0]           wr_data,
   input  logic                        ovf_wr,
   input  logic                        ext_wr,
   input  logic                        flag_wdata,
   output logic [BYTE_W*NUM_BYTES-1:0] count,
   output logic [BYTE_W*NUM_BYTES-1:0] capture,
   output logic                        ovf_flag,
   output logic                        ext_flag,
   output logic                        irq
);
   localparam int CW = BYTE_W * NUM_BYTES;

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (NUM_BYTES < 1) begin : g_bad_nb
      $error("NUM_BYTES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   crt_pkg::crt_mode_e mode;
   crt_pkg::flag_ctl_t ovf_ctl, ext_ctl;
   logic trig_fall, ext_hit, cap_grab, reload_now, step_en, term_evt;

   assign mode       = crt_pkg::crt_mode_e'(cap_mode);
   assign ext_hit    = trig_fall & ext_en;
   assign cap_grab   = ext_hit & (mode == crt_pkg::MODE_CAPTURE);
   assign reload_now = ext_hit & (mode == crt_pkg::MODE_RELOAD);
   assign step_en    = run & tick;

   crt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (trig_in),
      .fall (trig_fall)
   );

   crt_counter #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (cnt_byte_we),
      .wdata     (wr_data),
      .reload_now(reload_now),
      .reload_val(capture),
      .step_en   (step_en),
      .dir_down  (dir_down),
      .mode      (mode),
      .cnt       (count),
      .term_evt  (term_evt)
   );

   crt_capreg #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_we (cap_byte_we),
      .wdata   (wr_data),
      .grab    (cap_grab),
      .grab_val(count),
      .cap     (capture)
   );

   assign ovf_ctl = '{set: term_evt & ~(rx_baud | tx_baud), we: ovf_wr, wd: flag_wdata};
   assign ext_ctl = '{set: ext_hit, we: ext_wr, wd: flag_wdata};

   crt_flag u_ovf (.clk(clk), .rst_n(rst_n), .ctl(ovf_ctl), .q(ovf_flag));
   crt_flag u_ext (.clk(clk), .rst_n(rst_n), .ctl(ext_ctl), .q(ext_flag));

   assign irq = irq_en & (ovf_flag | ext_flag);
endmodule

// File: rtl/capture_reload_timer_sva.sv
module capture_reload_timer_sva #(
   parameter int CW = 16,
   parameter int NB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          tick,
   input logic          dir_down,
   input logic          rx_baud,
   input logic          tx_baud,
   input logic          irq_en,
   input logic          ext_en,
   input logic          ovf_wr,
   input logic          ext_wr,
   input logic          flag_wdata,
   input logic [NB-1:0] cnt_byte_we,
   input logic          ext_hit,
   input logic          cap_grab,
   input logic [CW-1:0] count,
   input logic [CW-1:0] capture,
   input logic          ovf_flag,
   input logic          ext_flag,
   input logic          irq
);
   localparam logic [CW-1:0] ALL_ONES = '1;

   p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !dir_down && cnt_byte_we == '0 && !ext_hit && count != ALL_ONES)
      |=> count == CW'($past(count) + 1'b1));

   p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && dir_down && cnt_byte_we == '0 && !ext_hit && count != capture)
      |=> count == CW'($past(count) - 1'b1));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_baud || tx_baud) && !ovf_flag && !(ovf_wr && flag_wdata)) |=> !ovf_flag);

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_grab |=> (capture == $past(count) && ext_flag));

   p_ext_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_en && !ext_flag && !(ext_wr && flag_wdata)) |=> !ext_flag);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_wr) |=> ovf_flag);

   p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ext_flag) |-> irq);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick) && cnt_byte_we == '0 && !ext_hit) |=> $stable(count));
endmodule

bind capture_reload_timer capture_reload_timer_sva #(.CW(CW), .NB(NUM_BYTES)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .tick       (tick),
   .dir_down   (dir_down),
   .rx_baud    (rx_baud),
   .tx_baud    (tx_baud),
   .irq_en     (irq_en),
   .ext_en     (ext_en),
   .ovf_wr     (ovf_wr),
   .ext_wr     (ext_wr),
   .flag_wdata (flag_wdata),
   .cnt_byte_we(cnt_byte_we),
   .ext_hit    (ext_hit),
   .cap_grab   (cap_grab),
   .count      (count),
   .capture    (capture),
   .ovf_flag   (ovf_flag),
   .ext_flag   (ext_flag),
   .irq        (irq)
);

// File: tb/tb_capture_reload_timer.sv
`timescale 1ns/1ps
module tb_capture_reload_timer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 0, tick = 0, dir_down = 0, cap_mode = 0, ext_en = 0, trig_in = 1;
   logic rx_baud = 0, tx_baud = 0, irq_en = 0;
   logic [1:0] cnt_byte_we = '0, cap_byte_we = '0;
   logic [7:0] wr_data = '0;
   logic ovf_wr = 0, ext_wr = 0, flag_wdata = 0;
   logic [15:0] count, capture;
   logic ovf_flag, ext_flag, irq;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   capture_reload_timer dut (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .dir_down(dir_down),
      .cap_mode(cap_mode), .ext_en(ext_en), .trig_in(trig_in), .rx_baud(rx_baud),
      .tx_baud(tx_baud), .irq_en(irq_en), .cnt_byte_we(cnt_byte_we),
      .cap_byte_we(cap_byte_we), .wr_data(wr_data), .ovf_wr(ovf_wr), .ext_wr(ext_wr),
      .flag_wdata(flag_wdata), .count(count), .capture(capture),
      .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model, updated at every rising edge
   int m_cnt = 0, m_cap = 0;
   bit m_ovf = 0, m_ext = 0;
   bit m_s1 = 1, m_s2 = 1, m_pv = 1;

   always @(posedge clk) begin
      bit hit, term;
      int nc, ncap;
      if (!rst_n) begin
         m_cnt = 0; m_cap = 0; m_ovf = 0; m_ext = 0;
         m_s1 = 1; m_s2 = 1; m_pv = 1;
      end else begin
         hit  = m_pv && !m_s2 && ext_en;
         term = 0;
         nc   = m_cnt;
         ncap = m_cap;
         if (cnt_byte_we != 0) begin
            if (cnt_byte_we[0]) nc = (nc & 'hFF00) | int'(wr_data);
            if (cnt_byte_we[1]) nc = (nc & 'h00FF) | (int'(wr_data) << 8);
         end else if (hit && !cap_mode) begin
            nc = m_cap;
         end else if (run && tick) begin
            if (!dir_down) begin
               if (m_cnt == 'hFFFF) begin term = 1; nc = cap_mode ? 0 : m_cap; end
               else nc = m_cnt + 1;
            end else begin
               if (m_cnt == m_cap) begin term = 1; nc = 'hFFFF; end
               else nc = m_cnt - 1;
            end
         end
         if (hit && cap_mode) ncap = m_cnt;
         else begin
            if (cap_byte_we[0]) ncap = (ncap & 'hFF00) | int'(wr_data);
            if (cap_byte_we[1]) ncap = (ncap & 'h00FF) | (int'(wr_data) << 8);
         end
         if (term && !rx_baud && !tx_baud) m_ovf = 1;
         else if (ovf_wr) m_ovf = flag_wdata;
         if (hit) m_ext = 1;
         else if (ext_wr) m_ext = flag_wdata;
         m_cnt = nc; m_cap = ncap;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = trig_in;
      end
      #2;
      if (rst_n) begin
         check("R1 model count", int'(count), m_cnt);
         check("R5 model capture", int'(capture), m_cap);
         check("R4 model ovf_flag", int'(ovf_flag), int'(m_ovf));
         check("R5 model ext_flag", int'(ext_flag), int'(m_ext));
         check("R8 model irq", int'(irq), int'(irq_en && (m_ovf || m_ext)));
      end
   end

   task automatic wr_cnt(input logic [15:0] v);
      cnt_byte_we = 2'b01; wr_data = v[7:0];  @(negedge clk);
      cnt_byte_we = 2'b10; wr_data = v[15:8]; @(negedge clk);
      cnt_byte_we = 2'b00;
   endtask

   task automatic wr_cap(input logic [15:0] v);
      cap_byte_we = 2'b01; wr_data = v[7:0];  @(negedge clk);
      cap_byte_we = 2'b10; wr_data = v[15:8]; @(negedge clk);
      cap_byte_we = 2'b00;
   endtask

   task automatic steps(input int n);
      run = 1; tick = 1;
      repeat (n) @(negedge clk);
      run = 0; tick = 0;
   endtask

   task automatic wr_ovf(input logic v);
      ovf_wr = 1; flag_wdata = v; @(negedge clk); ovf_wr = 0;
   endtask

   task automatic wr_ext(input logic v);
      ext_wr = 1; flag_wdata = v; @(negedge clk); ext_wr = 0;
   endtask

   task automatic trig_pulse();
      trig_in = 0; repeat (4) @(negedge clk);
      trig_in = 1; repeat (4) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R10 count after reset", int'(count), 0);
      check("R10 capture after reset", int'(capture), 0);
      check("R10 ovf after reset", int'(ovf_flag), 0);
      check("R10 ext after reset", int'(ext_flag), 0);
      check("R10 irq after reset", int'(irq), 0);

      wr_cnt(16'h12FE);
      check("R9 count bytes written", int'(count), 'h12FE);
      cnt_byte_we = 2'b01; wr_data = 8'hAA; run = 1; tick = 1;
      @(negedge clk);
      cnt_byte_we = 2'b00; run = 0; tick = 0;
      check("R9 low byte write blocks step", int'(count), 'h12AA);

      steps(5);
      check("R1 up count five steps", int'(count), 'h12AF);
      run = 1; tick = 0; repeat (3) @(negedge clk);
      check("R11 hold with tick low", int'(count), 'h12AF);
      run = 0; tick = 1; repeat (3) @(negedge clk);
      tick = 0;
      check("R11 hold with run low", int'(count), 'h12AF);

      wr_cap(16'h1234);
      check("R9 capture bytes written", int'(capture), 'h1234);
      wr_cnt(16'hFFFE);
      steps(1);
      check("R1 step to all-ones", int'(count), 'hFFFF);
      check("R4 no flag before wrap", int'(ovf_flag), 0);
      steps(1);
      check("R2 reload on up wrap", int'(count), 'h1234);
      check("R4 overflow flag set", int'(ovf_flag), 1);
      steps(2);
      check("R7 overflow flag sticky", int'(ovf_flag), 1);
      wr_ovf(0);
      check("R7 software clear", int'(ovf_flag), 0);

      rx_baud = 1; wr_cnt(16'hFFFF); steps(1);
      check("R4 rx baud reload", int'(count), 'h1234);
      check("R4 rx baud blocks flag", int'(ovf_flag), 0);
      rx_baud = 0; tx_baud = 1; wr_cnt(16'hFFFF); steps(1);
      check("R4 tx baud blocks flag", int'(ovf_flag), 0);
      tx_baud = 0;

      cap_mode = 1; wr_cnt(16'hFFFF); steps(1);
      check("R2 capture mode wraps to zero", int'(count), 0);
      check("R4 flag on capture-mode wrap", int'(ovf_flag), 1);
      wr_ovf(0);

      cap_mode = 0; dir_down = 1;
      wr_cap(16'h0010); wr_cnt(16'h0012);
      steps(1);
      check("R3 down step", int'(count), 'h0011);
      steps(1);
      check("R3 down to match", int'(count), 'h0010);
      check("R3 no flag before match step", int'(ovf_flag), 0);
      steps(1);
      check("R3 match loads all-ones", int'(count), 'hFFFF);
      check("R4 flag on down match", int'(ovf_flag), 1);
      steps(1);
      check("R3 continues down", int'(count), 'hFFFE);
      dir_down = 0; wr_ovf(0);

      cap_mode = 1; ext_en = 1; wr_cnt(16'h4321);
      trig_in = 0; repeat (2) @(negedge clk);
      check("R5 no action before third edge", int'(capture), 'h0010);
      @(negedge clk);
      check("R5 capture of count", int'(capture), 'h4321);
      check("R5 ext flag on capture", int'(ext_flag), 1);
      trig_in = 1; repeat (4) @(negedge clk);

      irq_en = 0; @(negedge clk);
      check("R8 irq gated off", int'(irq), 0);
      irq_en = 1; @(negedge clk);
      check("R8 irq from ext flag", int'(irq), 1);
      wr_ext(0);
      check("R8 irq drops after clear", int'(irq), 0);

      ext_en = 0; wr_cnt(16'h5555);
      trig_pulse();
      check("R6 capture unchanged", int'(capture), 'h4321);
      check("R6 ext flag stays low", int'(ext_flag), 0);
      check("R6 count unchanged", int'(count), 'h5555);

      cap_mode = 0; ext_en = 1;
      trig_pulse();
      check("R5 reload from trigger", int'(count), 'h4321);
      check("R5 ext flag on reload", int'(ext_flag), 1);
      wr_ext(0);

      wr_ext(1);
      check("R8 software ext set", int'(ext_flag), 1);
      check("R8 forced irq", int'(irq), 1);
      wr_ext(0);

      wr_cnt(16'hFFFF);
      run = 1; tick = 1; ovf_wr = 1; flag_wdata = 0;
      @(negedge clk);
      run = 0; tick = 0; ovf_wr = 0;
      check("R7 hardware set beats clear", int'(ovf_flag), 1);

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule